// File: doc/BRIEF.md
# Dual-Compare 8-bit Pulse Timer

This block is an up-counter that advances by one on each cycle in which its count-enable input is high. That input usually comes from a prescaler outside the block. Two compare registers are checked against the counter on every such tick. Each compare hit can drive one output pin: it can hold the pin, force it low, force it high, or toggle it. The counter can be made to return to zero on either compare. With clear-on-A, compare A sets the pulse period and compare B sets the pulse width, and no software action is needed once the block is set up.

Three events are tracked in sticky flags: a match on A, a match on B, and a counter wrap. Each flag has an enable bit and its own interrupt line. A two-bit code names the most urgent line that is asserted, under a fixed order: A first, then B, then wrap. Software reaches the counter, the compare values, the control fields and the flags through a plain register port. Writes are synchronous and reads are combinational.

Register map, addressed by `addr`:
- 0: counter.
- 1: compare A.
- 2: compare B.
- 3: control.
- 4: pin-action codes.
- 5: flags.
- 6 and 7: read as zero.

Top module: `dual_cmp_timer8`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the counter, all flags and `pulse_out` are 0, both compare registers read 0xFF, and control and pin-action read 0.
- R2: The counter adds one on each edge where `cnt_en` is high, and keeps its value when `cnt_en` is low.
- R3: A tick taken at count 0xFF that does not clear the counter wraps it to 0x00 and sets the wrap flag (bit 2 of address 5).
- R4: Control bits [1:0] select the clear source: 00 free-running, 01 clear to 0 on a tick that matches A, 10 clear to 0 on a tick that matches B, 11 no clear.
- R5: A tick on which the counter equals compare A sets flag bit 0 of address 5. A tick on which it equals compare B sets flag bit 1.
- R6: A flag stays set until a write to address 5 carries 0 in that bit. Writing 1 has no effect. A flag event in the same cycle as a clearing write leaves the flag set.
- R7: `irq_cmpa`, `irq_cmpb` and `irq_ovf` are high while their flag is set and their enable bit is set. The enable bits are control bits 2, 3 and 4.
- R8: `irq_sel` names the highest-priority asserted line: 01 for A, 10 for B, 11 for wrap, and 00 when no line is asserted.
- R9: Pin-action bits [1:0] apply on a match of A and bits [3:2] on a match of B: 00 hold, 01 drive 0, 10 drive 1, 11 toggle.
- R10: When A and B match on the same tick, only the code for A is applied to the pin.
- R11: With clear-on-A and pin-action 0110, the pin repeats every cmpA+1 ticks and stays high for cmpB+1 ticks (cmpB < cmpA).
- R12: A write to the counter in the same cycle as a tick wins: the written value is loaded, and no compare or wrap event is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count tick from the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| pulse_out | output | 1 | Compare-driven output pin |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |
| irq_sel | output | 2 | Highest-priority pending request code |

## Verification
Any fault in the counter shows up at the pin within one period. A skipped or doubled tick moves the period and width of the pulse by whole ticks, so the bench compares the pin against a model sample by sample. A flag that is lost or sticks can be seen on the very next cycle, through the interrupt lines, the priority code and a read of address 5. A wrong clear decision shows up in the counter value read right after the tick that matched.

// File: rtl/tmr8_pkg.sv
// Package: shared encodings for the dual-compare timer.
// Assumes: pin-action and clear-select codes are two bits wide.
package tmr8_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_RSVD = 2'b11
    } clr_sel_e;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'b00,
        IRQ_A    = 2'b01,
        IRQ_B    = 2'b10,
        IRQ_OVF  = 2'b11
    } irq_id_e;

    localparam int unsigned N_SRC   = 3;
    localparam int unsigned SRC_A   = 0;
    localparam int unsigned SRC_B   = 1;
    localparam int unsigned SRC_OVF = 2;

    // Next pin level for one action code applied to the current level.
    function automatic logic apply_act(input pin_act_e act, input logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_counter.sv
// Counter core: up-counter with load, two comparators, clear select and
// wrap detection. Events are combinational and valid only on a live tick
// (a tick with no software load in the same cycle).
// Assumes: cmp_a/cmp_b are stable register outputs.
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  clr_sel_e     clr_sel,
    output logic [W-1:0] count,
    output logic         hit_a,
    output logic         hit_b,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic live;
    logic do_clr;

    // Event decode for the current tick.
    always_comb begin
        live   = tick & ~load;
        hit_a  = live && (count == cmp_a);
        hit_b  = live && (count == cmp_b);
        do_clr = ((clr_sel == CLR_ON_A) && hit_a) || ((clr_sel == CLR_ON_B) && hit_b);
        wrap   = live && !do_clr && (count == CNT_MAX);
    end

    // Counter register: load beats clear, clear beats increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (load)   count <= load_val;
        else if (do_clr) count <= '0;
        else if (live)   count <= count + 1'b1;
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));
    a_r4_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && clr_sel == CLR_ON_A) |=> (count == '0));
    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/tmr8_irq.sv
// Flag and interrupt unit: sticky flags (set wins over clear), per-source
// enable gating and a fixed-priority source code (A > B > wrap).
// Assumes: clr_wr is a single-cycle write strobe to the flag register.
module tmr8_irq
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_evt,
    input  logic             clr_wr,
    input  logic [N_SRC-1:0] clr_data,
    input  logic [N_SRC-1:0] ie,
    output logic [N_SRC-1:0] flags,
    output logic [N_SRC-1:0] irq_line,
    output irq_id_e          irq_sel
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        // One sticky flag: event sets, written zero clears.
        always_ff @(posedge clk) begin
            if (!rst_n)                     flags[i] <= 1'b0;
            else if (set_evt[i])            flags[i] <= 1'b1;
            else if (clr_wr && !clr_data[i]) flags[i] <= 1'b0;
        end
    end

    // Request lines gated by enables.
    assign irq_line = flags & ie;

    // Fixed-priority encode of the pending requests.
    always_comb begin
        if (irq_line[SRC_A])        irq_sel = IRQ_A;
        else if (irq_line[SRC_B])   irq_sel = IRQ_B;
        else if (irq_line[SRC_OVF]) irq_sel = IRQ_OVF;
        else                        irq_sel = IRQ_NONE;
    end

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[SRC_A] && !clr_wr) |=> flags[SRC_A]);
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[SRC_B] |=> flags[SRC_B]);
    a_r8_top_a: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line[SRC_A] |-> (irq_sel == IRQ_A));
    a_r8_none: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel == IRQ_NONE) |-> (irq_line == '0));
endmodule

// File: rtl/tmr8_pin.sv
// Pin driver: applies the action code of the compare that hit; A overrides
// B when both hit in the same tick.
// Assumes: hit_a/hit_b are already qualified with a live tick.
module tmr8_pin
    import tmr8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic [3:0] act_sel,
    output logic       pin
);
    pin_act_e act;

    // Pick the action: A first, then B, else hold.
    always_comb begin
        if (hit_a)      act = pin_act_e'(act_sel[1:0]);
        else if (hit_b) act = pin_act_e'(act_sel[3:2]);
        else            act = ACT_HOLD;
    end

    // Pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= apply_act(act, pin);
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_a && !hit_b) |=> $stable(pin));
    a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && act_sel[1:0] == 2'b11) |=> (pin != $past(pin)));
    a_r10_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && hit_b && act_sel[1:0] == 2'b10) |=> pin);
endmodule

// File: rtl/dual_cmp_timer8.sv
// Top: register file plus counter core, flag/interrupt unit and pin driver.
// Assumes: W >= 5 so control fields fit; reads are combinational on addr.
module dual_cmp_timer8
    import tmr8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         pulse_out,
    output logic         irq_cmpa,
    output logic         irq_cmpb,
    output logic         irq_ovf,
    output logic [1:0]   irq_sel
);
    localparam logic [2:0] A_CNT  = 3'd0;
    localparam logic [2:0] A_CMPA = 3'd1;
    localparam logic [2:0] A_CMPB = 3'd2;
    localparam logic [2:0] A_CTRL = 3'd3;
    localparam logic [2:0] A_ACT  = 3'd4;
    localparam logic [2:0] A_FLAG = 3'd5;
    localparam logic [W-1:0] CMP_RST = {W{1'b1}};

    logic [W-1:0]     cmp_a, cmp_b, count;
    clr_sel_e         clr_sel;
    logic [N_SRC-1:0] ie, flags, irq_line, evt;
    logic [3:0]       act_sel;
    logic             hit_a, hit_b, wrap;
    irq_id_e          sel_code;

    // Software-owned configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_a   <= CMP_RST;
            cmp_b   <= CMP_RST;
            clr_sel <= CLR_NONE;
            ie      <= '0;
            act_sel <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CMPA: cmp_a <= wr_data;
                A_CMPB: cmp_b <= wr_data;
                A_CTRL: begin
                    clr_sel <= clr_sel_e'(wr_data[1:0]);
                    ie      <= wr_data[4:2];
                end
                A_ACT:  act_sel <= wr_data[3:0];
                default: ;
            endcase
        end
    end

    tmr8_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cnt_en),
        .load(wr_en && addr == A_CNT), .load_val(wr_data),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .clr_sel(clr_sel),
        .count(count), .hit_a(hit_a), .hit_b(hit_b), .wrap(wrap)
    );

    assign evt = {wrap, hit_b, hit_a};

    tmr8_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_evt(evt),
        .clr_wr(wr_en && addr == A_FLAG), .clr_data(wr_data[N_SRC-1:0]),
        .ie(ie), .flags(flags), .irq_line(irq_line), .irq_sel(sel_code)
    );

    tmr8_pin u_pin (
        .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b),
        .act_sel(act_sel), .pin(pulse_out)
    );

    assign irq_cmpa = irq_line[SRC_A];
    assign irq_cmpb = irq_line[SRC_B];
    assign irq_ovf  = irq_line[SRC_OVF];
    assign irq_sel  = sel_code;

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_CNT:   rd_data = count;
            A_CMPA:  rd_data = cmp_a;
            A_CMPB:  rd_data = cmp_b;
            A_CTRL:  rd_data = {{(W-5){1'b0}}, ie, clr_sel};
            A_ACT:   rd_data = {{(W-4){1'b0}}, act_sel};
            A_FLAG:  rd_data = {{(W-N_SRC){1'b0}}, flags};
            default: rd_data = '0;
        endcase
    end

    a_r7_line_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> flags[SRC_OVF]);
    a_r1_reset_cmp: assert property (@(posedge clk)
        !rst_n |=> (cmp_a == CMP_RST && cmp_b == CMP_RST));
endmodule

// File: tb/dual_cmp_timer8_tb.sv
module dual_cmp_timer8_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       pulse_out, irq_cmpa, irq_cmpb, irq_ovf;
    logic [1:0] irq_sel;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_cmp_timer8 u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pulse_out(pulse_out),
        .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf), .irq_sel(irq_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; #1; d = rd_data;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(3'd0, v); chk("R1 count", v, 8'h00);
        rd(3'd1, v); chk("R1 cmpA", v, 8'hFF);
        rd(3'd2, v); chk("R1 cmpB", v, 8'hFF);
        rd(3'd3, v); chk("R1 ctrl", v, 8'h00);
        rd(3'd5, v); chk("R1 flags", v, 8'h00);
        chk("R1 pin+irq", {pulse_out, irq_cmpa, irq_cmpb, irq_ovf, irq_sel}, 0);
    endtask

    task automatic t_count();
        logic [7:0] v;
        do_reset();
        ticks(5);
        rd(3'd0, v); chk("R2 five ticks", v, 8'h05);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R2 hold without enable", v, 8'h05);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        do_reset();
        wr(3'd1, 8'h10); wr(3'd2, 8'h11);
        wr(3'd0, 8'hFD);
        ticks(2);
        rd(3'd5, v); chk("R3 no flag before wrap", v, 8'h00);
        ticks(1);
        rd(3'd0, v); chk("R3 wrapped count", v, 8'h00);
        rd(3'd5, v); chk("R3 wrap flag", v, 8'h04);
        wr(3'd5, 8'h03);
        rd(3'd5, v); chk("R6 write 0 clears, write 1 inert", v, 8'h00);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        do_reset();
        wr(3'd1, 8'h03); wr(3'd2, 8'h02); wr(3'd3, 8'h01);
        ticks(4);
        rd(3'd0, v); chk("R4 clear on A", v, 8'h00);
        rd(3'd5, v); chk("R5 flags A and B", v, 8'h03);
        wr(3'd3, 8'h02); wr(3'd0, 8'h00);
        ticks(3);
        rd(3'd0, v); chk("R4 clear on B", v, 8'h00);
        wr(3'd3, 8'h03); wr(3'd0, 8'h00);
        ticks(4);
        rd(3'd0, v); chk("R4 code 11 no clear", v, 8'h04);
        wr(3'd3, 8'h00); wr(3'd0, 8'h00);
        ticks(4);
        rd(3'd0, v); chk("R4 free run past A", v, 8'h04);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        do_reset();
        wr(3'd1, 8'h30); wr(3'd2, 8'h40);
        wr(3'd3, 8'h0C);                     // enables A and B
        wr(3'd0, 8'h30); ticks(1);
        chk("R7 A line", {irq_cmpa, irq_cmpb, irq_ovf}, 3'b100);
        chk("R8 sel A", irq_sel, 2'b01);
        wr(3'd0, 8'h40); ticks(1);
        chk("R8 A over B", irq_sel, 2'b01);
        wr(3'd0, 8'hFF); ticks(1);
        chk("R7 wrap masked", irq_ovf, 1'b0);
        wr(3'd5, 8'h06);
        chk("R8 sel B", irq_sel, 2'b10);
        wr(3'd3, 8'h10);                     // only wrap enabled
        chk("R7 B masked, wrap on", {irq_cmpa, irq_cmpb, irq_ovf}, 3'b001);
        chk("R8 sel wrap", irq_sel, 2'b11);
        wr(3'd5, 8'h00);
        chk("R8 sel none", irq_sel, 2'b00);
        // set wins: clearing write while A matches
        wr(3'd0, 8'h30);
        @(negedge clk); wr_en = 1'b1; addr = 3'd5; wr_data = 8'h00; cnt_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; cnt_en = 1'b0;
        rd(3'd5, v); chk("R6 set wins over clear", v, 8'h01);
    endtask

    task automatic t_pin();
        do_reset();
        wr(3'd1, 8'h07);
        wr(3'd4, 8'h03); wr(3'd0, 8'h07); ticks(1);
        chk("R9 A toggle up", pulse_out, 1'b1);
        wr(3'd0, 8'h07); ticks(1);
        chk("R9 A toggle down", pulse_out, 1'b0);
        wr(3'd4, 8'h02); wr(3'd0, 8'h07); ticks(1);
        chk("R9 A high", pulse_out, 1'b1);
        wr(3'd4, 8'h00); wr(3'd0, 8'h07); ticks(1);
        chk("R9 A hold", pulse_out, 1'b1);
        wr(3'd4, 8'h01); wr(3'd0, 8'h07); ticks(1);
        chk("R9 A low", pulse_out, 1'b0);
        wr(3'd2, 8'h10);
        wr(3'd4, 8'h08); wr(3'd0, 8'h10); ticks(1);
        chk("R9 B high", pulse_out, 1'b1);
        wr(3'd4, 8'h0C); wr(3'd0, 8'h10); ticks(1);
        chk("R9 B toggle", pulse_out, 1'b0);
    endtask

    task automatic t_both();
        do_reset();
        wr(3'd1, 8'h05); wr(3'd2, 8'h05);
        wr(3'd4, 8'h06); wr(3'd0, 8'h05); ticks(1);
        chk("R10 A high beats B low", pulse_out, 1'b1);
        wr(3'd4, 8'h04); wr(3'd0, 8'h05); ticks(1);
        chk("R10 A hold beats B low", pulse_out, 1'b1);
    endtask

    task automatic t_pulse();
        int miss = 0;
        do_reset();
        wr(3'd1, 8'h09); wr(3'd2, 8'h03);
        wr(3'd3, 8'h01); wr(3'd4, 8'h06);
        @(negedge clk); cnt_en = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (pulse_out !== (((k - 1) % 10 == 9) || (k > 10 && (k - 1) % 10 <= 2)))
                miss++;
        end
        cnt_en = 1'b0;
        chk("R11 period 10 width 4 mismatches", miss, 0);
    endtask

    task automatic t_load();
        logic [7:0] v;
        do_reset();
        wr(3'd1, 8'h20); wr(3'd0, 8'h20);
        @(negedge clk); wr_en = 1'b1; addr = 3'd0; wr_data = 8'h50; cnt_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; cnt_en = 1'b0;
        rd(3'd0, v); chk("R12 load beats tick", v, 8'h50);
        rd(3'd5, v); chk("R12 no event on load", v, 8'h00);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_count();
        t_wrap();
        t_clear();
        t_irq();
        t_pin();
        t_both();
        t_pulse();
        t_load();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule